// File: doc/BRIEF.md
# Phased Set-Associative Cache Lookup

This block answers read requests against a 4-way set-associative store. Each access takes two phases. In the first phase, which is the cycle the request is accepted, only the tag sub-arrays of all ways are read and compared with the request tag. No data sub-array is switched on in that cycle. In the second phase, and only when one way matched, the data sub-array of that one way is read. The selected word goes into an output buffer, and that buffer drives the response. A miss reads no data sub-array at all. A hit therefore costs one data-array read instead of four, and it takes one cycle more than a lookup that reads tags and data in parallel.

Requests arrive on a valid/ready port carrying a word address. The address splits, from most to least significant, into tag, set index and word offset. The response is a one-cycle pulse that carries a hit flag and the data word. A line-fill port installs a whole line into a way the requester chooses. In that one cycle it writes the tag, sets the valid bit and writes every word of the line. The block brings out the per-way tag and data read enables, along with two running counts of them, so that array activity can be measured from outside.

Top module: `phased_cache_rd`

## Requirements
- R1: After reset, `req_ready` is 1, `resp_valid` is 0, no tag or data enable is high, and both activity counters are 0.
- R2: In the cycle a request is accepted (`req_valid` and `req_ready` both high), every bit of `tag_rd_en` is 1 and every bit of `data_rd_en` is 0.
- R3: In the cycle after a request that hits, `data_rd_en` is one-hot on the matching way, with bit i standing for way i, and `tag_rd_en` is all zero.
- R4: On a miss, `data_rd_en` stays all zero in both phases. The response carries `resp_hit` = 0 and `resp_data` = 0.
- R5: `resp_valid` is high for exactly one cycle. It comes two rising edges after the edge that accepts the request.
- R6: In the second phase `req_ready` is 0, and a request held on the port in that cycle enables no tag array.
- R7: A hit needs the line's valid bit to be set as well as an equal tag. After reset every line misses, even for a request whose tag bits equal whatever the arrays hold.
- R8: A fill with `fill_valid` = 1 writes the tag (`fill_addr[15:6]`), sets the valid bit of set `fill_addr[5:2]` in way `fill_way`, and writes the line. Later lookups of that tag and set hit in that way. The requester keeps any tag in at most one way of a set.
- R9: A fill takes precedence over a lookup. While `fill_valid` is 1, `req_ready` is 0 and no tag array is enabled.
- R10: `tag_rd_cnt` grows by 4 for each accepted lookup. `data_rd_cnt` grows by 1 for each hit and by 0 for each miss.
- R11: Ways of one set hold different tags at the same time. A new fill into a way replaces that way's old tag, which then misses.
- R12: `resp_data` on a hit is word `req_addr[1:0]` of the line, where word w is `fill_line[w*32 +: 32]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Block can accept a lookup this cycle |
| req_addr | input | 16 | Word address: tag [15:6], set [5:2], word [1:0] |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response is a hit |
| resp_data | output | 32 | Buffered data word, zero on a miss |
| fill_valid | input | 1 | Install a line this cycle |
| fill_way | input | 2 | Way that receives the line |
| fill_addr | input | 16 | Tag and set of the line; word bits unused |
| fill_line | input | 128 | Line contents, word 0 in the low bits |
| tag_rd_en | output | 4 | Per-way tag sub-array read enables |
| data_rd_en | output | 4 | Per-way data sub-array read enables |
| tag_rd_cnt | output | 16 | Running count of tag sub-array reads |
| data_rd_cnt | output | 16 | Running count of data sub-array reads |

## Verification
Each result has a fixed cycle. Tag enables and the ready drop show up combinationally in the acceptance cycle. Data enables appear in the cycle after the accepting edge. Response fields and the data counter are valid after the second edge. The tag counter is valid after the first edge. Every scenario task drives inputs on a falling edge and samples one time step later, once per cycle. Each check is tied to the cycle count from acceptance given above, so a result one cycle early or late is reported. Counter checks use counts taken just before each lookup, so every lookup is judged on its own increments.

// File: rtl/pc_pkg.sv
`timescale 1ns/1ps
package pc_pkg;
   typedef enum logic [0:0] {
      PH_TAG  = 1'b0,
      PH_DATA = 1'b1
   } phase_t;
endpackage

// File: rtl/pc_tag_way.sv
`timescale 1ns/1ps
module pc_tag_way #(
   parameter int SETS  = 16,
   parameter int TAG_W = 10,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0] rd_tag,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   output logic             match
);
   logic [SETS-1:0]  vld;
   logic [TAG_W-1:0] tags [SETS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld         <= '0;
      else if (wr_en) vld[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en) tags[wr_idx] <= wr_tag;
   end

   assign match = rd_en && vld[rd_idx] && (tags[rd_idx] == rd_tag);
endmodule

// File: rtl/pc_data_way.sv
`timescale 1ns/1ps
module pc_data_way #(
   parameter int SETS   = 16,
   parameter int WORDS  = 4,
   parameter int DATA_W = 32,
   localparam int IDX_W  = $clog2(SETS),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int LINE_W = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [OFF_W-1:0]  rd_off,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line,
   output logic [DATA_W-1:0] rd_word
);
   logic [WORDS-1:0][DATA_W-1:0] mem [SETS];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_idx] <= wr_line;
   end

   // disabled sub-array contributes zero to the way OR
   assign rd_word = rd_en ? mem[rd_idx][rd_off] : '0;
endmodule

// File: rtl/pc_ctrl.sv
`timescale 1ns/1ps
module pc_ctrl
   import pc_pkg::*;
#(
   parameter int WAYS   = 4,
   parameter int IDX_W  = 4,
   parameter int OFF_W  = 2,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              fill_valid,
   input  logic [IDX_W-1:0]  req_idx,
   input  logic [OFF_W-1:0]  req_off,
   input  logic [WAYS-1:0]   hit_vec,
   input  logic [DATA_W-1:0] way_word,
   output logic              req_ready,
   output logic              accept,
   output logic [WAYS-1:0]   data_en,
   output logic [IDX_W-1:0]  idx_q,
   output logic [OFF_W-1:0]  off_q,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_data
);
   phase_t          ph;
   logic [WAYS-1:0] hit_q;

   assign req_ready = (ph == PH_TAG) && !fill_valid;
   assign accept    = req_valid && req_ready;
   assign data_en   = (ph == PH_DATA) ? hit_q : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph         <= PH_TAG;
         hit_q      <= '0;
         idx_q      <= '0;
         off_q      <= '0;
         resp_valid <= 1'b0;
         resp_hit   <= 1'b0;
         resp_data  <= '0;
      end else begin
         resp_valid <= (ph == PH_DATA);
         if (ph == PH_DATA) begin
            ph        <= PH_TAG;
            resp_hit  <= |hit_q;
            resp_data <= (|hit_q) ? way_word : '0;
         end else if (accept) begin
            ph    <= PH_DATA;
            hit_q <= hit_vec;
            idx_q <= req_idx;
            off_q <= req_off;
         end
      end
   end

   a_r6_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   a_r5_resp_slot: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> ##1 resp_valid);
   a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);
endmodule

// File: rtl/phased_cache_rd.sv
`timescale 1ns/1ps
module phased_cache_rd #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int WAYS   = 4,
   parameter int SETS   = 16,
   parameter int WORDS  = 4,
   parameter int CNT_W  = 16,
   localparam int IDX_W  = $clog2(SETS),
   localparam int OFF_W  = $clog2(WORDS),
   localparam int WAY_W  = $clog2(WAYS),
   localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
   localparam int LINE_W = WORDS * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [DATA_W-1:0] resp_data,
   input  logic              fill_valid,
   input  logic [WAY_W-1:0]  fill_way,
   input  logic [ADDR_W-1:0] fill_addr,
   input  logic [LINE_W-1:0] fill_line,
   output logic [WAYS-1:0]   tag_rd_en,
   output logic [WAYS-1:0]   data_rd_en,
   output logic [CNT_W-1:0]  tag_rd_cnt,
   output logic [CNT_W-1:0]  data_rd_cnt
);
   if (WAYS < 2 || (WAYS & (WAYS - 1)) != 0) begin : g_bad_ways
      $error("WAYS must be a power of two, at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (WORDS < 2 || (WORDS & (WORDS - 1)) != 0) begin : g_bad_words
      $error("WORDS must be a power of two, at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W leaves no tag bits");
   end

   logic [TAG_W-1:0]  req_tag, fill_tag;
   logic [IDX_W-1:0]  req_idx, fill_idx, idx_q;
   logic [OFF_W-1:0]  req_off, off_q;
   logic              accept;
   logic [WAYS-1:0]   hit_vec, fill_we;
   logic [DATA_W-1:0] way_word [WAYS];
   logic [DATA_W-1:0] word_or;

   assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
   assign req_idx  = req_addr[OFF_W +: IDX_W];
   assign req_off  = req_addr[OFF_W-1:0];
   assign fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
   assign fill_idx = fill_addr[OFF_W +: IDX_W];

   assign tag_rd_en = {WAYS{accept}};

   for (genvar w = 0; w < WAYS; w++) begin : g_way
      assign fill_we[w] = fill_valid && (fill_way == WAY_W'(w));

      pc_tag_way #(.SETS(SETS), .TAG_W(TAG_W)) u_tag (
         .clk    (clk),
         .rst_n  (rst_n),
         .rd_en  (tag_rd_en[w]),
         .rd_idx (req_idx),
         .rd_tag (req_tag),
         .wr_en  (fill_we[w]),
         .wr_idx (fill_idx),
         .wr_tag (fill_tag),
         .match  (hit_vec[w])
      );

      pc_data_way #(.SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_data (
         .clk     (clk),
         .rd_en   (data_rd_en[w]),
         .rd_idx  (idx_q),
         .rd_off  (off_q),
         .wr_en   (fill_we[w]),
         .wr_idx  (fill_idx),
         .wr_line (fill_line),
         .rd_word (way_word[w])
      );
   end

   always_comb begin
      word_or = '0;
      for (int w = 0; w < WAYS; w++) word_or |= way_word[w];
   end

   pc_ctrl #(.WAYS(WAYS), .IDX_W(IDX_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .fill_valid (fill_valid),
      .req_idx    (req_idx),
      .req_off    (req_off),
      .hit_vec    (hit_vec),
      .way_word   (word_or),
      .req_ready  (req_ready),
      .accept     (accept),
      .data_en    (data_rd_en),
      .idx_q      (idx_q),
      .off_q      (off_q),
      .resp_valid (resp_valid),
      .resp_hit   (resp_hit),
      .resp_data  (resp_data)
   );

   // activity counters
   logic [CNT_W-1:0] tag_pop, data_pop;
   always_comb begin
      tag_pop  = '0;
      data_pop = '0;
      for (int w = 0; w < WAYS; w++) begin
         tag_pop  += CNT_W'(tag_rd_en[w]);
         data_pop += CNT_W'(data_rd_en[w]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag_rd_cnt  <= '0;
         data_rd_cnt <= '0;
      end else begin
         tag_rd_cnt  <= tag_rd_cnt + tag_pop;
         data_rd_cnt <= data_rd_cnt + data_pop;
      end
   end

   a_r2_no_data_in_tag_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (|tag_rd_en) |-> (data_rd_en == '0));
   a_r4_miss_reads_no_data: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> ($past(data_rd_en) == '0));
   a_r4_miss_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (resp_data == '0));
   a_r9_fill_first: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |-> (tag_rd_en == '0));
   a_r10_data_step: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_W'(data_rd_cnt - $past(data_rd_cnt)) <= CNT_W'(1));
endmodule

// File: tb/tb_phased_cache_rd.sv
`timescale 1ns/1ps
module tb_phased_cache_rd;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic         req_ready;
   logic [15:0]  req_addr = '0;
   logic         resp_valid, resp_hit;
   logic [31:0]  resp_data;
   logic         fill_valid = 1'b0;
   logic [1:0]   fill_way = '0;
   logic [15:0]  fill_addr = '0;
   logic [127:0] fill_line = '0;
   logic [3:0]   tag_rd_en, data_rd_en;
   logic [15:0]  tag_rd_cnt, data_rd_cnt;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   phased_cache_rd dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_data(resp_data),
      .fill_valid(fill_valid), .fill_way(fill_way), .fill_addr(fill_addr),
      .fill_line(fill_line),
      .tag_rd_en(tag_rd_en), .data_rd_en(data_rd_en),
      .tag_rd_cnt(tag_rd_cnt), .data_rd_cnt(data_rd_cnt)
   );

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [127:0] mk_line(logic [15:0] seed);
      logic [127:0] l;
      for (int w = 0; w < 4; w++) l[w*32 +: 32] = {seed, 16'(w) ^ 16'h5a00};
      return l;
   endfunction

   function automatic logic [15:0] mk_addr(logic [9:0] tag, logic [3:0] idx, logic [1:0] off);
      return {tag, idx, off};
   endfunction

   task automatic do_fill(logic [1:0] way, logic [9:0] tag, logic [3:0] idx, logic [15:0] seed);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_way   = way;
      fill_addr  = mk_addr(tag, idx, 2'd0);
      fill_line  = mk_line(seed);
      #1;
      chk("R9", "ready during fill", 64'(req_ready), 64'd0);
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // R2 R3 R4 R5 R6 R10 R12: full two-phase lookup with per-cycle checks
   task automatic do_lookup(string req, logic [15:0] addr, bit exp_hit,
                            logic [1:0] exp_way, logic [31:0] exp_data);
      logic [15:0] t0, d0;
      @(negedge clk);
      t0 = tag_rd_cnt;
      d0 = data_rd_cnt;
      req_valid = 1'b1;
      req_addr  = addr;
      #1;
      chk("R2", "ready in tag phase", 64'(req_ready), 64'd1);
      chk("R2", "tag enables", 64'(tag_rd_en), 64'hf);
      chk("R2", "data enables in tag phase", 64'(data_rd_en), 64'd0);
      @(negedge clk);
      #1;
      chk("R6", "ready in data phase", 64'(req_ready), 64'd0);
      chk("R6", "tag enables with request held", 64'(tag_rd_en), 64'd0);
      if (exp_hit) chk("R3", "data enable on hit", 64'(data_rd_en), 64'(4'b1 << exp_way));
      else         chk("R4", "data enable on miss", 64'(data_rd_en), 64'd0);
      chk("R5", "no response after one edge", 64'(resp_valid), 64'd0);
      req_valid = 1'b0;
      @(negedge clk);
      #1;
      chk("R5", "response after two edges", 64'(resp_valid), 64'd1);
      chk(req, "hit flag", 64'(resp_hit), 64'(exp_hit));
      chk(exp_hit ? "R12" : "R4", "response data", 64'(resp_data), exp_hit ? 64'(exp_data) : 64'd0);
      chk("R10", "tag count step", 64'(16'(tag_rd_cnt - t0)), 64'd4);
      chk("R10", "data count step", 64'(16'(data_rd_cnt - d0)), exp_hit ? 64'd1 : 64'd0);
      @(negedge clk);
      #1;
      chk("R5", "response one cycle only", 64'(resp_valid), 64'd0);
   endtask

   task automatic t_reset();
      chk("R1", "ready", 64'(req_ready), 64'd1);
      chk("R1", "resp_valid", 64'(resp_valid), 64'd0);
      chk("R1", "tag enables", 64'(tag_rd_en), 64'd0);
      chk("R1", "data enables", 64'(data_rd_en), 64'd0);
      chk("R1", "tag count", 64'(tag_rd_cnt), 64'd0);
      chk("R1", "data count", 64'(data_rd_cnt), 64'd0);
   endtask

   task automatic t_cold_miss();
      // R7: invalid lines never hit
      do_lookup("R7", mk_addr(10'h000, 4'd0, 2'd0), 1'b0, 2'd0, 32'd0);
      do_lookup("R7", mk_addr(10'h3ff, 4'd9, 2'd1), 1'b0, 2'd0, 32'd0);
   endtask

   task automatic t_fill_hit();
      logic [127:0] l = mk_line(16'ha1a1);
      do_fill(2'd2, 10'h03a, 4'd5, 16'ha1a1);
      do_lookup("R8", mk_addr(10'h03a, 4'd5, 2'd0), 1'b1, 2'd2, l[31:0]);
      do_lookup("R12", mk_addr(10'h03a, 4'd5, 2'd3), 1'b1, 2'd2, l[127:96]);
      do_lookup("R4", mk_addr(10'h03a, 4'd6, 2'd0), 1'b0, 2'd0, 32'd0);
   endtask

   task automatic t_two_ways();
      logic [127:0] la = mk_line(16'ha1a1);
      logic [127:0] lb = mk_line(16'hb2b2);
      do_fill(2'd0, 10'h011, 4'd5, 16'hb2b2);
      do_lookup("R11", mk_addr(10'h011, 4'd5, 2'd1), 1'b1, 2'd0, lb[63:32]);
      do_lookup("R11", mk_addr(10'h03a, 4'd5, 2'd2), 1'b1, 2'd2, la[95:64]);
      do_lookup("R4", mk_addr(10'h012, 4'd5, 2'd2), 1'b0, 2'd0, 32'd0);
   endtask

   task automatic t_replace();
      logic [127:0] lc = mk_line(16'hc3c3);
      do_fill(2'd2, 10'h022, 4'd5, 16'hc3c3);
      do_lookup("R11", mk_addr(10'h03a, 4'd5, 2'd0), 1'b0, 2'd0, 32'd0);
      do_lookup("R11", mk_addr(10'h022, 4'd5, 2'd2), 1'b1, 2'd2, lc[95:64]);
   endtask

   task automatic t_fill_precedence();
      logic [127:0] ld = mk_line(16'hd4d4);
      @(negedge clk);
      fill_valid = 1'b1;
      fill_way   = 2'd3;
      fill_addr  = mk_addr(10'h155, 4'd12, 2'd0);
      fill_line  = ld;
      req_valid  = 1'b1;
      req_addr   = mk_addr(10'h155, 4'd12, 2'd1);
      #1;
      chk("R9", "ready with fill", 64'(req_ready), 64'd0);
      chk("R9", "tag enables with fill", 64'(tag_rd_en), 64'd0);
      @(negedge clk);
      fill_valid = 1'b0;
      req_valid  = 1'b0;
      #1;
      chk("R9", "no data read after blocked request", 64'(data_rd_en), 64'd0);
      @(negedge clk);
      #1;
      chk("R9", "no response to blocked request", 64'(resp_valid), 64'd0);
      do_lookup("R9", mk_addr(10'h155, 4'd12, 2'd1), 1'b1, 2'd3, ld[63:32]);
   endtask

   bit finished = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_cold_miss();
      t_fill_hit();
      t_two_ways();
      t_replace();
      t_fill_precedence();
      repeat (2) @(negedge clk);
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end
endmodule